// File: doc/BRIEF.md
# Aperture-Based Address Remap Unit

This block sits on one bus master's address path and turns each 32-bit master address into a target-slave select and an address local to that slave. The address space is split into sixteen 256 MB windows, and the top four address bits pick the window. Each window has a small configuration entry that holds a slave identifier and a 256 MB-granular offset. The remapped address keeps the low 28 bits of the master address. The entry's offset replaces the top four bits. The window's own base address is not added.

Software programs the sixteen entries through a simple write/read port. One index selects the entry for both writing and reading. Translation has one register stage, so a new request can be accepted on every cycle. A chip with several masters instantiates one copy per master, and each copy has its own table. After reset the table holds a default map. The lower half of the address space passes straight through to slave 0. The upper half folds onto the same slave at slave addresses 0x0000_0000 to 0x7FFF_FFFF.

Top module: `addr_remap`

## Requirements
- R1: The window used for a request is given by req_addr[31:28], so window n covers master addresses n*0x1000_0000 to n*0x1000_0000+0x0FFF_FFFF.
- R2: For an accepted request, rsp_addr equals {offset, req_addr[27:0]}, where offset is the entry's 4-bit offset field. The window base is never added.
- R3: Each entry is 8 bits wide. Bits [3:0] hold the slave identifier, and it appears on rsp_slave. Bits [7:4] hold the offset.
- R4: After reset, entry k reads back as {k mod 8, 4'h0}. This means slave 0 with offset k mod 8.
- R5: rsp_valid equals req_valid from the previous cycle. A request may be presented on every cycle, and each one yields its result exactly one cycle later.
- R6: A write with cfg_we=1 stores cfg_wdata at entry cfg_idx. The stored value shows on cfg_rdata from the next cycle on. Requests presented in later cycles use the new entry. A request presented in the same cycle as the write still uses the old entry.
- R7: A write changes only the entry at cfg_idx. Every other entry keeps its value.
- R8: While req_valid is 0, rsp_slave and rsp_addr hold their last values.
- R9: While reset is asserted, rsp_valid, rsp_slave and rsp_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronized inside the block. |
| cfg_we | input | 1 | Writes cfg_wdata into the entry at cfg_idx |
| cfg_idx | input | 4 | Entry index for writing and reading |
| cfg_wdata | input | 8 | Entry write value: {offset[3:0], slave[3:0]} |
| cfg_rdata | output | 8 | Current value of the entry at cfg_idx |
| req_valid | input | 1 | Master address is valid this cycle |
| req_addr | input | 32 | Master address |
| rsp_valid | output | 1 | Translated result is valid |
| rsp_slave | output | 4 | Target slave identifier |
| rsp_addr | output | 32 | Slave-local address |

## Verification
The embedded assertions check the following on every cycle:
- the one-cycle valid relation;
- the holding of outputs while idle;
- the pass-through of the low 28 address bits;
- that a write lands in its entry;
- that a write leaves every other entry untouched.

Only the bench scenarios can show the window selection, the offset replacement and the slave select against an independent model of the table. The same goes for the reset map and the same-cycle write-versus-request ordering on one window.

// File: rtl/remap_pkg.sv
package remap_pkg;
  // Master address width and the number of upper bits that pick a window.
  parameter int unsigned ADDR_W   = 32;
  parameter int unsigned WIN_W    = 4;
  // Slave identifier width.
  parameter int unsigned SLV_W    = 4;
  // Default map: windows wrap onto this many 256 MB slots of one slave.
  parameter int unsigned DEF_WRAP = 8;
  parameter int unsigned DEF_SLV  = 0;
endpackage

// File: rtl/remap_rst_sync.sv
// Asserts reset immediately and releases it only on a clock edge.
module remap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/remap_table.sv
// Per-window configuration entries: {offset, slave}.
module remap_table #(
  parameter int unsigned WIN_W    = 4,
  parameter int unsigned SLV_W    = 4,
  parameter int unsigned DEF_WRAP = 8,
  parameter int unsigned DEF_SLV  = 0,
  localparam int unsigned NUM_WIN = 1 << WIN_W,
  localparam int unsigned ENT_W   = WIN_W + SLV_W
) (
  input  logic                            clk,
  input  logic                            rst_ni,
  input  logic                            we,
  input  logic [WIN_W-1:0]                idx,
  input  logic [ENT_W-1:0]                wdata,
  output logic [ENT_W-1:0]                rdata,
  output logic [NUM_WIN-1:0][ENT_W-1:0]   tbl_o
);
  logic [NUM_WIN-1:0][ENT_W-1:0] tbl_q;
  logic [NUM_WIN-1:0]            ld_en;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_ent
    localparam logic [WIN_W-1:0] DOFS = WIN_W'(k % DEF_WRAP);
    localparam logic [SLV_W-1:0] DSLV = SLV_W'(DEF_SLV);

    // Clock enable for this entry.
    always_comb begin
      ld_en[k] = we && (idx == WIN_W'(k));
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)       tbl_q[k] <= {DOFS, DSLV};
      else if (ld_en[k]) tbl_q[k] <= wdata;
    end

    // R7: a write aimed elsewhere leaves this entry alone
    a_r7_other_stable: assert property (@(posedge clk) disable iff (!rst_ni)
      (we && idx != WIN_W'(k)) |=> $stable(tbl_q[k]));
  end

  assign rdata = tbl_q[idx];
  assign tbl_o = tbl_q;

  // R6: the written value is in the addressed entry on the next cycle
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_ni)
    we |=> (tbl_q[$past(idx)] == $past(wdata)));

  // R7: no write means no entry changes
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_ni)
    !we |=> $stable(tbl_q));
endmodule

// File: rtl/remap_lookup.sv
// Window select, offset replacement and the single output register stage.
module remap_lookup #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_W    = 4,
  parameter int unsigned SLV_W    = 4,
  localparam int unsigned NUM_WIN = 1 << WIN_W,
  localparam int unsigned ENT_W   = WIN_W + SLV_W,
  localparam int unsigned LOW_W   = ADDR_W - WIN_W
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic [NUM_WIN-1:0][ENT_W-1:0] tbl,
  input  logic                          req_valid,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic                          rsp_valid,
  output logic [SLV_W-1:0]              rsp_slave,
  output logic [ADDR_W-1:0]             rsp_addr
);
  logic [WIN_W-1:0]  win;
  logic [ENT_W-1:0]  ent;
  logic [SLV_W-1:0]  slave_d, slave_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              valid_q;

  always_comb begin
    win     = req_addr[ADDR_W-1 -: WIN_W];
    ent     = tbl[win];
    slave_d = ent[SLV_W-1:0];
    addr_d  = {ent[ENT_W-1 -: WIN_W], req_addr[LOW_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= req_valid;
  end

  // The data registers load only when a request is accepted.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      slave_q <= '0;
      addr_q  <= '0;
    end else if (req_valid) begin
      slave_q <= slave_d;
      addr_q  <= addr_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_slave = slave_q;
  assign rsp_addr  = addr_q;

  // R5: each request produces a valid result on the next cycle
  a_r5_valid_next: assert property (@(posedge clk) disable iff (!rst_ni)
    req_valid |=> rsp_valid);
  // R5: no request means no result on the next cycle
  a_r5_idle_next: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_valid |=> !rsp_valid);
  // R8: the outputs hold while no request is accepted
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_valid |=> ($stable(rsp_addr) && $stable(rsp_slave)));
  // R2: the low address bits pass through unchanged
  a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_ni)
    req_valid |=> (rsp_addr[LOW_W-1:0] == $past(req_addr[LOW_W-1:0])));
endmodule

// File: rtl/addr_remap.sv
module addr_remap
  import remap_pkg::*;
#(
  localparam int unsigned ENT_W   = WIN_W + SLV_W,
  localparam int unsigned NUM_WIN = 1 << WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WIN_W-1:0]  cfg_idx,
  input  logic [ENT_W-1:0]  cfg_wdata,
  output logic [ENT_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [SLV_W-1:0]  rsp_slave,
  output logic [ADDR_W-1:0] rsp_addr
);
  logic                          rst_ni;
  logic [NUM_WIN-1:0][ENT_W-1:0] tbl;

  remap_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  remap_table #(
    .WIN_W    (WIN_W),
    .SLV_W    (SLV_W),
    .DEF_WRAP (DEF_WRAP),
    .DEF_SLV  (DEF_SLV)
  ) u_tbl (
    .clk    (clk),
    .rst_ni (rst_ni),
    .we     (cfg_we),
    .idx    (cfg_idx),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .tbl_o  (tbl)
  );

  remap_lookup #(
    .ADDR_W (ADDR_W),
    .WIN_W  (WIN_W),
    .SLV_W  (SLV_W)
  ) u_lkp (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .tbl       (tbl),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_slave (rsp_slave),
    .rsp_addr  (rsp_addr)
  );
endmodule

// File: tb/addr_remap_bench.sv
`timescale 1ns/1ps
module addr_remap_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic [3:0]  rsp_slave;
  logic [31:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0]  model [16];
  logic [3:0]  exp_slave;
  logic [31:0] exp_addr;

  addr_remap u_addr_remap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_slave (rsp_slave),
    .rsp_addr  (rsp_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] default_entry(int k);
    return {4'(k % 8), 4'h0};
  endfunction

  function automatic logic [31:0] xlate(logic [7:0] e, logic [31:0] a);
    return {e[7:4], a[27:0]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: inputs are driven at the falling edge, and outputs are compared just after the next rising edge.
  task automatic cycle(bit we, logic [3:0] idx, logic [7:0] wd, bit rv,
                       logic [31:0] ra, string tag);
    @(negedge clk);
    cfg_we = we; cfg_idx = idx; cfg_wdata = wd;
    req_valid = rv; req_addr = ra;
    if (rv) begin
      exp_slave = model[ra[31:28]][3:0];
      exp_addr  = xlate(model[ra[31:28]], ra);
    end
    @(posedge clk);
    if (we) model[idx] = wd;
    #1;
    chk(rsp_valid == rv, {"R5 ", tag}, 32'(rsp_valid), 32'(rv));
    chk(rsp_slave == exp_slave, {"R3 ", tag}, 32'(rsp_slave), 32'(exp_slave));
    chk(rsp_addr == exp_addr, {"R2 ", tag}, rsp_addr, exp_addr);
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0; cfg_idx = 4'(i);
      #1;
      chk(cfg_rdata == model[i], req, 32'(cfg_rdata), 32'(model[i]));
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    cfg_we = 0; cfg_idx = 0; cfg_wdata = 0; req_valid = 0; req_addr = 0;
    exp_slave = 0; exp_addr = 0;
    for (int i = 0; i < 16; i++) model[i] = default_entry(i);
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    // R9: drive a request during reset; the outputs must stay 0.
    req_valid = 1'b1; req_addr = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R9 valid", 32'(rsp_valid), 0);
    chk(rsp_slave == 4'h0, "R9 slave", 32'(rsp_slave), 0);
    chk(rsp_addr == 32'h0, "R9 addr", rsp_addr, 0);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R4: check the default table.
    read_all("R4 default entry");

    // R1 and R2: the default map folds the upper half down.
    cycle(0, 0, 0, 1, 32'hC123_4567, "R1 default window 12");
    chk(rsp_addr == 32'h4123_4567, "R1 fold 0xC -> 0x4", rsp_addr, 32'h4123_4567);
    cycle(0, 0, 0, 1, 32'h2ABC_DEF0, "R1 default window 2");
    cycle(0, 0, 0, 1, 32'hFFFF_FFFF, "R1 top of space");
    chk(rsp_addr == 32'h7FFF_FFFF, "R2 top folds", rsp_addr, 32'h7FFF_FFFF);

    // R8: the outputs hold while idle.
    cycle(0, 0, 0, 0, 32'h1234_5678, "R8 idle 1");
    cycle(0, 0, 0, 0, 32'h9999_9999, "R8 idle 2");

    // R6: a same-cycle write and request on window 3 uses the old entry,
    // and the next request uses the new entry.
    cycle(1, 4'd3, 8'hA5, 1, 32'h3000_0010, "R6 same cycle old");
    chk(rsp_addr == 32'h3000_0010, "R6 old entry used", rsp_addr, 32'h3000_0010);
    cycle(0, 0, 0, 1, 32'h3000_0010, "R6 next cycle new");
    chk(rsp_slave == 4'h5 && rsp_addr == 32'hA000_0010, "R6 new entry used",
        {rsp_slave, rsp_addr[27:0]}, 32'h5000_0010);

    // R7: the other entries are untouched after a write.
    cycle(1, 4'd15, 8'h3C, 0, 0, "R7 write 15");
    read_all("R7 entry readback");

    // Random mix of writes and requests.
    for (int n = 0; n < 400; n++) begin
      bit          we = ($urandom_range(0, 9) < 3);
      bit          rv = ($urandom_range(0, 9) < 7);
      logic [3:0]  ix = 4'($urandom_range(0, 15));
      logic [7:0]  wd = 8'($urandom);
      logic [31:0] ad = $urandom;
      cycle(we, ix, wd, rv, ad, "random");
    end
    read_all("R6 final readback");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule